// File: doc/BRIEF.md
# Byte-Interleaved Sample FIFO Controller

This block sits between a 16-bit sampling converter and a byte-wide host register bus. Each converter result arrives with a one-cycle valid strobe. The block stores it in a byte-organised queue as two bytes, the low byte first and then the high byte. The default queue holds 512 samples, which is 1024 bytes. The host drains the queue one byte per read strobe. It has two read strobes, one for the low-byte offset and one for the high-byte offset, and both pop the same queue. The host must keep the byte pairs aligned itself. When the queue is empty, a read returns the last byte again.

The block keeps three status flags: empty, half full and a sticky overflow flag. A sample is dropped whenever fewer than two byte slots are free. The overflow flag then freezes the stored data against further writes until the host writes a flush command. Reads can still drain the queue while it is frozen.

An interrupt request output works in one of two ways, chosen by a buffer-enable bit in a byte-wide control register:
- With the bit set, the request follows the fill level.
- With the bit clear, the request pulses once for every converter completion event.

A control write that carries the flush bit empties the queue and leaves every other control bit as it was.

Top module: `sample_byte_fifo`

## Requirements
- R1: After reset the queue is empty (empty_o=1, half_o=0, ovf_o=0), irq_o=0, rd_data_o=0x00 and cfg_o=0x00.
- R2: An accepted sample takes two byte slots, the low byte (bits 7:0) ahead of the high byte (bits 15:8). Bytes leave in the order they were stored.
- R3: A cycle with rd_lo_i or rd_hi_i high pops one byte when the queue is not empty. That byte appears on rd_data_o after the clock edge that ends the cycle, and both strobes draw from the same queue.
- R4: A read strobe while the queue is empty leaves rd_data_o at the last byte it showed and moves no pointer. A sample pushed later is therefore the next byte read.
- R5: A sample that arrives when fewer than two byte slots are free sets ovf_o and is dropped. While ovf_o is 1, every later sample is also dropped, reads still pop, and only a flush clears ovf_o.
- R6: empty_o is 1 exactly when the queue holds 0 bytes. half_o is 1 exactly when it holds at least 512 bytes (half the byte capacity).
- R7: With control bit 5 (buffer enable) set, irq_o equals half_o. With it clear, irq_o is 1 for exactly the cycle after each cycle in which done_i is high.
- R8: A control write with bit 7 set empties the queue and clears ovf_o, while cfg_o (control bits 6:0) keeps its value. A control write with bit 7 clear loads bits 6:0 into cfg_o.
- R9: A sample is never split. At 1022 stored bytes a sample is accepted and fills the queue. At 1023 stored bytes it is counted as overflow.
- R10: A push and a pop in the same cycle both take effect: the byte count rises by one. Free space for that push is judged on the count at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid_i | input | 1 | Converter sample strobe |
| smp_data_i | input | 16 | Converter sample |
| rd_lo_i | input | 1 | Host read at the low-byte offset |
| rd_hi_i | input | 1 | Host read at the high-byte offset |
| rd_data_o | output | 8 | Byte returned to the host |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control write data, bit 7 = flush, bit 5 = buffer enable |
| cfg_o | output | 7 | Stored control bits 6:0 |
| done_i | input | 1 | Conversion or scan completion event |
| empty_o | output | 1 | Queue empty |
| half_o | output | 1 | Queue at least half full |
| ovf_o | output | 1 | Sticky overflow |
| irq_o | output | 1 | Interrupt request |

## Verification
Most internal faults in this block show up at the ports within one pop:
- A read or write pointer that slips by one swaps the low and high bytes of every later sample on rd_data_o.
- A lost push shows as empty_o rising one pair of reads too early.

Faults in the count show later, at the half-full and full boundaries. These are exercised exactly: at 510 and 512 bytes, at 1022 and 1023 bytes, and by a full 1024-byte drain whose every byte is compared. A wrong overflow freeze shows as a sample that reappears after the queue has been drained. A flush that disturbs the control bits shows on cfg_o on the next cycle.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

    localparam int FLUSH_BIT = 7;

    // stored control bits 6:0; bit 5 selects level-driven interrupts
    typedef struct packed {
        logic       spare6;
        logic       buf_en;
        logic [4:0] spare_lo;
    } cfg_t;

endpackage

// File: rtl/sbf_cfg_reg.sv
module sbf_cfg_reg
    import sbf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output logic       flush_o,
    output cfg_t       cfg_o
);

    typedef struct packed {
        cfg_t cfg;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        flush_o = wr_i && wdata_i[FLUSH_BIT];
        if (wr_i && !wdata_i[FLUSH_BIT]) begin
            st_d.cfg = cfg_t'(wdata_i[6:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;

    // R8: a flush write leaves the stored bits alone
    p_flush_keeps_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[FLUSH_BIT]) |=> $stable(cfg_o));

endmodule

// File: rtl/sbf_byte_ram.sv
module sbf_byte_ram #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [BYTE_W-1:0] wlo_i,
    input  logic [BYTE_W-1:0] whi_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [BYTE_W-1:0] rdata_o
);

    localparam int WORDS = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem_q [WORDS];
    logic [ADDR_W-1:0] waddr_hi;

    assign waddr_hi = waddr_i + ADDR_W'(1);

    // two byte lanes written in one cycle: low byte, then the next slot
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i]  <= wlo_i;
            mem_q[waddr_hi] <= whi_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/sbf_ptr_ctrl.sv
module sbf_ptr_ctrl #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              flush_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [ADDR_W-1:0] raddr_o,
    output logic              pop_ok_o,
    output logic [ADDR_W:0]   count_o,
    output logic              ovf_o
);

    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] CAP      = CNT_W'(1 << ADDR_W);
    localparam logic [CNT_W-1:0] PUSH_MAX = CAP - CNT_W'(2);

    typedef struct packed {
        logic [ADDR_W-1:0] wptr;
        logic [ADDR_W-1:0] rptr;
        logic [CNT_W-1:0]  cnt;
        logic              ovf;
    } st_t;

    st_t  st_q, st_d;
    logic room, push_ok, pop_ok, ovf_hit;

    always_comb begin
        room    = (st_q.cnt <= PUSH_MAX);
        push_ok = push_i && !st_q.ovf && room && !flush_i;
        ovf_hit = push_i && !st_q.ovf && !room;
        pop_ok  = pop_i && (st_q.cnt != '0) && !flush_i;

        st_d = st_q;
        if (flush_i) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wptr = st_q.wptr + ADDR_W'(2);
            if (pop_ok)  st_d.rptr = st_q.rptr + ADDR_W'(1);
            st_d.cnt = st_q.cnt + (push_ok ? CNT_W'(2) : '0)
                                - (pop_ok  ? CNT_W'(1) : '0);
            if (ovf_hit) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign we_o     = push_ok;
    assign waddr_o  = st_q.wptr;
    assign raddr_o  = st_q.rptr;
    assign pop_ok_o = pop_ok;
    assign count_o  = st_q.cnt;
    assign ovf_o    = st_q.ovf;

    // R6: the byte count never exceeds capacity
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CAP);

    // R5: overflow is sticky until a flush
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !flush_i) |=> ovf_o);

    // R5: a frozen queue never grows
    p_no_grow_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !flush_i) |=> (count_o <= $past(count_o)));

    // R8: flush empties and clears overflow
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (count_o == '0 && !ovf_o));

    // R10: push with pop nets one byte
    p_push_pop_net_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && pop_ok_o) |=> (count_o == $past(count_o) + CNT_W'(1)));

endmodule

// File: rtl/sample_byte_fifo.sv
module sample_byte_fifo
    import sbf_pkg::*;
#(
    parameter int BYTE_W        = 8,
    parameter int DEPTH_SAMPLES = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid_i,
    input  logic [2*BYTE_W-1:0] smp_data_i,
    input  logic                rd_lo_i,
    input  logic                rd_hi_i,
    output logic [BYTE_W-1:0]   rd_data_o,
    input  logic                ctl_wr_i,
    input  logic [7:0]          ctl_wdata_i,
    output logic [6:0]          cfg_o,
    input  logic                done_i,
    output logic                empty_o,
    output logic                half_o,
    output logic                ovf_o,
    output logic                irq_o
);

    localparam int CAP_BYTES = 2 * DEPTH_SAMPLES;
    localparam int ADDR_W    = $clog2(CAP_BYTES);
    localparam int CNT_W     = ADDR_W + 1;
    localparam logic [CNT_W-1:0] HALF = CNT_W'(CAP_BYTES / 2);

    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
        logic              done;
    } st_t;

    st_t               st_q, st_d;
    cfg_t              cfg;
    logic              flush, we, pop_ok;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [CNT_W-1:0]  count;
    logic [BYTE_W-1:0] ram_rdata;

    sbf_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_wr_i),
        .wdata_i (ctl_wdata_i),
        .flush_o (flush),
        .cfg_o   (cfg)
    );

    sbf_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (smp_valid_i),
        .pop_i    (rd_lo_i || rd_hi_i),
        .flush_i  (flush),
        .we_o     (we),
        .waddr_o  (waddr),
        .raddr_o  (raddr),
        .pop_ok_o (pop_ok),
        .count_o  (count),
        .ovf_o    (ovf_o)
    );

    sbf_byte_ram #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_ram (
        .clk     (clk),
        .we_i    (we),
        .waddr_i (waddr),
        .wlo_i   (smp_data_i[BYTE_W-1:0]),
        .whi_i   (smp_data_i[2*BYTE_W-1:BYTE_W]),
        .raddr_i (raddr),
        .rdata_o (ram_rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = done_i;
        if (pop_ok) st_d.rdata = ram_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o = st_q.rdata;
    assign cfg_o     = cfg;
    assign empty_o   = (count == '0);
    assign half_o    = (count >= HALF);
    assign irq_o     = cfg.buf_en ? half_o : st_q.done;

    // R4: a read of an empty queue re-presents the last byte
    p_empty_read_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && (rd_lo_i || rd_hi_i)) |=> $stable(rd_data_o));

    // R7: in event mode each completion raises the request next cycle
    p_event_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !cfg.buf_en && !ctl_wr_i) |=> irq_o);

    // R6: empty and half full never hold together
    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_o && half_o));

endmodule

// File: tb/sample_byte_fifo_tb.sv
module sample_byte_fifo_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid_i = 1'b0;
    logic [15:0] smp_data_i = '0;
    logic        rd_lo_i = 1'b0;
    logic        rd_hi_i = 1'b0;
    logic [7:0]  rd_data_o;
    logic        ctl_wr_i = 1'b0;
    logic [7:0]  ctl_wdata_i = '0;
    logic [6:0]  cfg_o;
    logic        done_i = 1'b0;
    logic        empty_o, half_o, ovf_o, irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    sample_byte_fifo u_dut (
        .clk(clk), .rst_n(rst_n),
        .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
        .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i), .rd_data_o(rd_data_o),
        .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i), .cfg_o(cfg_o),
        .done_i(done_i), .empty_o(empty_o), .half_o(half_o),
        .ovf_o(ovf_o), .irq_o(irq_o)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            summary();
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] samp(input int i);
        logic [8:0] v;
        v = 9'(i);
        return {v[8:1] ^ 8'hC3, v[7:0]};
    endfunction

    task automatic push(input logic [15:0] d);
        @(negedge clk);
        smp_valid_i = 1'b1;
        smp_data_i  = d;
        @(posedge clk); #1;
        smp_valid_i = 1'b0;
    endtask

    task automatic pop(input bit hi, output logic [7:0] b);
        @(negedge clk);
        if (hi) rd_hi_i = 1'b1; else rd_lo_i = 1'b1;
        @(posedge clk); #1;
        rd_lo_i = 1'b0;
        rd_hi_i = 1'b0;
        b = rd_data_o;
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk);
        ctl_wr_i = 1'b1;
        ctl_wdata_i = v;
        @(posedge clk); #1;
        ctl_wr_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 empty", empty_o, 1);
        check("R1 half", half_o, 0);
        check("R1 ovf", ovf_o, 0);
        check("R1 irq", irq_o, 0);
        check("R1 rd_data", rd_data_o, 8'h00);
        check("R1 cfg", cfg_o, 7'h00);
    endtask

    task automatic t_order();
        logic [7:0] b;
        push(16'hBEEF);
        push(16'h1234);
        check("R6 not empty", empty_o, 0);
        pop(0, b); check("R2 first low byte", b, 8'hEF);
        pop(1, b); check("R3 hi strobe pops high", b, 8'hBE);
        pop(1, b); check("R3 hi strobe pops next low", b, 8'h34);
        pop(0, b); check("R3 lo strobe pops high", b, 8'h12);
        check("R6 empty after drain", empty_o, 1);
    endtask

    task automatic t_empty();
        logic [7:0] b;
        pop(0, b); check("R4 empty read repeats", b, 8'h12);
        pop(1, b); check("R4 empty read repeats again", b, 8'h12);
        push(16'hA55A);
        pop(0, b); check("R4 no pointer moved", b, 8'h5A);
        pop(1, b); check("R4 following byte", b, 8'hA5);
        check("R4 empty again", empty_o, 1);
    endtask

    task automatic t_flush_cfg();
        ctl_write(8'h25);
        check("R8 cfg load", cfg_o, 7'h25);
        push(16'h0102);
        push(16'h0304);
        ctl_write(8'hDA);
        check("R8 flush keeps cfg", cfg_o, 7'h25);
        check("R8 flush empties", empty_o, 1);
        ctl_write(8'h00);
        check("R8 cfg clear", cfg_o, 7'h00);
    endtask

    task automatic t_irq_event();
        check("R7 event mode idle", irq_o, 0);
        @(negedge clk); done_i = 1'b1;
        @(posedge clk); #1; done_i = 1'b0;
        check("R7 irq after done", irq_o, 1);
        @(posedge clk); #1;
        check("R7 irq one cycle", irq_o, 0);
    endtask

    task automatic drain_check(input int first, input int nbytes, input string tag);
        logic [7:0] b;
        logic [15:0] s;
        int bad = 0;
        for (int k = first; k < first + nbytes; k++) begin
            s = samp(k / 2);
            pop(k[0], b);
            if (b !== ((k % 2) ? s[15:8] : s[7:0])) bad++;
        end
        check(tag, bad, 0);
    endtask

    task automatic t_fill();
        logic [7:0] b;
        ctl_write(8'h20);
        for (int i = 0; i < 255; i++) push(samp(i));
        check("R6 half at 510 bytes", half_o, 0);
        check("R7 level irq low", irq_o, 0);
        push(samp(255));
        check("R6 half at 512 bytes", half_o, 1);
        check("R7 level irq high", irq_o, 1);
        for (int i = 256; i < 512; i++) push(samp(i));
        check("R5 no ovf when full", ovf_o, 0);
        push(16'hDEAD);
        check("R5 ovf set", ovf_o, 1);
        pop(0, b);
        check("R5 first byte", b, samp(0)[7:0]);
        push(16'hBEEF);
        check("R5 ovf sticky", ovf_o, 1);
        drain_check(1, 512, "R5 contents kept part 1");
        check("R6 half below 512", half_o, 0);
        drain_check(513, 511, "R5 contents kept part 2");
        check("R5 drained", empty_o, 1);
        push(16'h7777);
        check("R5 frozen drops sample", empty_o, 1);
        ctl_write(8'h80);
        check("R8 flush clears ovf", ovf_o, 0);
        check("R8 flush keeps enable", cfg_o, 7'h20);
        push(16'h6655);
        pop(0, b);
        check("R5 accepts after flush", b, 8'h55);
        ctl_write(8'h80);
    endtask

    task automatic t_atomic();
        logic [7:0] b;
        for (int i = 0; i < 511; i++) push(samp(i));
        push(samp(511));
        check("R9 accepted at 1022", ovf_o, 0);
        pop(0, b);
        push(16'hCAFE);
        check("R9 one slot is overflow", ovf_o, 1);
        drain_check(1, 1023, "R9 no split sample");
        ctl_write(8'h80);
    endtask

    task automatic t_simul();
        logic [7:0] b;
        push(16'h1111);
        @(negedge clk);
        smp_valid_i = 1'b1; smp_data_i = 16'h2233; rd_lo_i = 1'b1;
        @(posedge clk); #1;
        smp_valid_i = 1'b0; rd_lo_i = 1'b0;
        check("R10 pop in push cycle", rd_data_o, 8'h11);
        pop(1, b); check("R10 byte 2", b, 8'h11);
        pop(0, b); check("R10 byte 3", b, 8'h33);
        check("R10 one byte left", empty_o, 0);
        pop(1, b); check("R10 byte 4", b, 8'h22);
        check("R10 empty", empty_o, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_order();
        t_empty();
        t_flush_cfg();
        t_irq_event();
        t_fill();
        t_atomic();
        t_simul();
        summary();
    end

endmodule